// File: doc/BRIEF.md
# Configurable Counter Pair with Watchdog

This block holds two 32-bit counters that software can set up in one of three ways. In chained mode they form one 64-bit up-counter. In split mode they are two 32-bit timers that run independently. In watchdog mode they form a 64-bit down-counter, and software must keep reloading it. In the two period modes, each counter advances either on an internal tick or on rising edges of its own input pin. When a counter passes its programmed period it raises a one-clock event and toggles its output pin, which gives a square wave whose period is set by software.

The internal tick is the system clock divided by a fixed factor of six. The block is programmed through a simple write port with four word addresses. Address 0 holds the mode and the clock sources. Addresses 1 and 2 hold the low and high period words. Any write to address 3 services the watchdog. The watchdog expiry output is a level. Once set, it stays set until reset.

Top module: `timer64_wd`

## Requirements
- R1: After reset, the mode is off (code 0), both period words are zero, and lo_evt, hi_evt, lo_pin_out, hi_pin_out and wd_expired are all low.
- R2: The internal tick occurs once every 6 clocks, counted from the last control write. With the internal source and period P, lo_evt pulses for one clock exactly 6·(P+1) clocks after the control write, and again every 6·(P+1) clocks after that.
- R3: Mode code 1 (chained) counts a single 64-bit value, with the high word from address 2 and the low word from address 1. It uses the low-half source and signals on lo_evt only. hi_evt never fires in this mode.
- R4: Mode code 2 (split) runs two independent counters. The low counter uses the period at address 1 and control bit 2 as its source select. The high counter uses the period at address 2 and control bit 3 as its source select. Each half pulses its own event every period+1 advances.
- R5: When a source-select bit is set, that half advances once for each rising edge of its input pin, however long the pin stays high. The pin passes through two synchroniser flops and one history flop, so the count changes 3 clocks after the pin rises.
- R6: Each event toggles the output pin of its own half in the same clock. A control write returns both output pins to low.
- R7: Mode code 3 (watchdog) loads {addr2, addr1} into the counter on entry. It decrements the counter once per internal tick. wd_expired rises on the tick that takes the count to zero, 6·N clocks after entry for a load value N ≥ 1. No lo_evt or hi_evt fires in this mode.
- R8: In watchdog mode, a write to address 3 before expiry reloads {addr2, addr1} and restarts the tick divider, so that expiry moves to 6·N clocks after the service write.
- R9: Once wd_expired is high, it stays high until reset. Service writes and control writes do not clear it.
- R10: A write to address 0 clears both counters, the tick divider and any event in flight. Counting in the new mode starts from zero, and the first event comes a full period after the write.
- R11: Mode code 0 (off) never advances either counter and never raises an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 control, 1 low period, 2 high period, 3 watchdog service |
| wr_data | input | 32 | Write data. Control bits [1:0] mode, bit 2 low source external, bit 3 high source external |
| lo_pin_in | input | 1 | External count input for the low half |
| hi_pin_in | input | 1 | External count input for the high half |
| lo_pin_out | output | 1 | Low-half output, toggles on each low event |
| hi_pin_out | output | 1 | High-half output, toggles on each high event |
| lo_evt | output | 1 | One-clock low-half (or chained) period event |
| hi_evt | output | 1 | One-clock high-half period event |
| wd_expired | output | 1 | Sticky watchdog expiry |

## Verification
The block's only observable state is when its events and pin toggles occur. So a wrong prescaler phase, a missed clear or a bad carry shows up as an event in the wrong clock. The bench predicts each event to the exact cycle. Any event that arrives early, late, in the wrong half or in a mode that should be silent is reported the clock it appears, or the clock after its expected slot passes. A watchdog fault shows up as a change in wd_expired one clock away from the predicted expiry, or as expiry dropping after it was set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_CHAIN = 2'd1,
        MODE_SPLIT = 2'd2,
        MODE_WDOG  = 2'd3
    } tmr_mode_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PER_L = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PER_H = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_SVC   = 2'd3;

    localparam int CTRL_LO_EXT = 2;
    localparam int CTRL_HI_EXT = 3;

endpackage

// File: rtl/tick_div.sv
module tick_div #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart || st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        tick = (st_q.cnt == LAST) && !restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/pin_edge.sv
module pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin};
        st_d.prev = st_q.sync[STAGES-1];
        rise      = st_q.sync[STAGES-1] && !st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R5

endmodule

// File: rtl/count_core.sv
module count_core
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_mode_e        mode,
    input  logic             clear,
    input  tmr_mode_e        clear_mode,
    input  logic [W-1:0]     per_lo,
    input  logic [W-1:0]     per_hi,
    input  logic             lo_adv,
    input  logic             hi_adv,
    input  logic             tick,
    input  logic             service,
    output logic             lo_evt,
    output logic             hi_evt,
    output logic             lo_out,
    output logic             hi_out,
    output logic             expired
);
    localparam int FW = 2 * W;

    typedef struct packed {
        logic [W-1:0] lo_cnt;
        logic [W-1:0] hi_cnt;
        logic         lo_evt;
        logic         hi_evt;
        logic         lo_out;
        logic         hi_out;
        logic         expired;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [FW-1:0] full_q, full_n, per_full;

    assign full_q   = {st_q.hi_cnt, st_q.lo_cnt};
    assign per_full = {per_hi, per_lo};

    always_comb begin
        st_d        = st_q;
        st_d.lo_evt = 1'b0;
        st_d.hi_evt = 1'b0;
        full_n      = full_q;
        if (clear) begin
            full_n      = (clear_mode == MODE_WDOG) ? per_full : '0;
            st_d.lo_out = 1'b0;
            st_d.hi_out = 1'b0;
        end else begin
            unique case (mode)
                MODE_CHAIN: begin
                    if (lo_adv) begin
                        if (full_q == per_full) begin
                            full_n      = '0;
                            st_d.lo_evt = 1'b1;
                            st_d.lo_out = !st_q.lo_out;
                        end else begin
                            full_n = full_q + 1'b1;
                        end
                    end
                end
                MODE_SPLIT: begin
                    if (lo_adv) begin
                        if (st_q.lo_cnt == per_lo) begin
                            full_n[W-1:0] = '0;
                            st_d.lo_evt   = 1'b1;
                            st_d.lo_out   = !st_q.lo_out;
                        end else begin
                            full_n[W-1:0] = st_q.lo_cnt + 1'b1;
                        end
                    end
                    if (hi_adv) begin
                        if (st_q.hi_cnt == per_hi) begin
                            full_n[FW-1:W] = '0;
                            st_d.hi_evt    = 1'b1;
                            st_d.hi_out    = !st_q.hi_out;
                        end else begin
                            full_n[FW-1:W] = st_q.hi_cnt + 1'b1;
                        end
                    end
                end
                MODE_WDOG: begin
                    if (!st_q.expired) begin
                        if (service) begin
                            full_n = per_full;
                        end else if (tick) begin
                            if (full_q <= FW'(1)) begin
                                full_n       = '0;
                                st_d.expired = 1'b1;
                            end else begin
                                full_n = full_q - 1'b1;
                            end
                        end
                    end
                end
                default: begin
                end
            endcase
        end
        st_d.lo_cnt = full_n[W-1:0];
        st_d.hi_cnt = full_n[FW-1:W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_evt  = st_q.lo_evt;
    assign hi_evt  = st_q.hi_evt;
    assign lo_out  = st_q.lo_out;
    assign hi_out  = st_q.hi_out;
    assign expired = st_q.expired;

    AST_WD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired); // R9
    AST_LO_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_evt |=> !lo_evt); // R2
    AST_LO_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_evt |-> (lo_out != $past(lo_out))); // R6
    AST_HI_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hi_evt |-> (hi_out != $past(hi_out))); // R6

endmodule

// File: rtl/timer64_wd.sv
module timer64_wd
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int CLK_DIV = 6,
    parameter int SYNC_N  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        lo_pin_in,
    input  logic        hi_pin_in,
    output logic        lo_pin_out,
    output logic        hi_pin_out,
    output logic        lo_evt,
    output logic        hi_evt,
    output logic        wd_expired
);
    typedef struct packed {
        tmr_mode_e        mode;
        logic             lo_ext;
        logic             hi_ext;
        logic [CNT_W-1:0] per_lo;
        logic [CNT_W-1:0] per_hi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic ctrl_wr, svc_wr, tick, lo_adv, hi_adv;
    logic [1:0] pin_vec, rise_vec;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign svc_wr  = wr_en && (wr_addr == ADDR_SVC) && (cfg_q.mode == MODE_WDOG);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: begin
                    cfg_d.mode   = tmr_mode_e'(wr_data[1:0]);
                    cfg_d.lo_ext = wr_data[CTRL_LO_EXT];
                    cfg_d.hi_ext = wr_data[CTRL_HI_EXT];
                end
                ADDR_PER_L: cfg_d.per_lo = wr_data[CNT_W-1:0];
                ADDR_PER_H: cfg_d.per_hi = wr_data[CNT_W-1:0];
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    tick_div #(.DIV(CLK_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr || svc_wr),
        .tick    (tick)
    );

    assign pin_vec = {hi_pin_in, lo_pin_in};

    for (genvar g = 0; g < 2; g++) begin : g_pin
        pin_edge #(.STAGES(SYNC_N)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_vec[g]),
            .rise  (rise_vec[g])
        );
    end

    assign lo_adv = cfg_q.lo_ext ? rise_vec[0] : tick;
    assign hi_adv = cfg_q.hi_ext ? rise_vec[1] : tick;

    count_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (cfg_q.mode),
        .clear      (ctrl_wr),
        .clear_mode (tmr_mode_e'(wr_data[1:0])),
        .per_lo     (cfg_q.per_lo),
        .per_hi     (cfg_q.per_hi),
        .lo_adv     (lo_adv),
        .hi_adv     (hi_adv),
        .tick       (tick),
        .service    (svc_wr),
        .lo_evt     (lo_evt),
        .hi_evt     (hi_evt),
        .lo_out     (lo_pin_out),
        .hi_out     (hi_pin_out),
        .expired    (wd_expired)
    );

    AST_CHAIN_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MODE_CHAIN) |-> !hi_evt); // R3
    AST_WDOG_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MODE_WDOG) |-> (!lo_evt && !hi_evt)); // R7
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MODE_OFF) |-> (!lo_evt && !hi_evt)); // R11

endmodule

// File: tb/timer64_wd_tb.sv
module timer64_wd_tb;

    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        lo_pin_in = 1'b0;
    logic        hi_pin_in = 1'b0;
    logic        lo_pin_out, hi_pin_out, lo_evt, hi_evt, wd_expired;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int lo_seen = 0;
    int hi_seen = 0;
    string cur_req = "R1";
    int lo_q[$];
    int hi_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    timer64_wd #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lo_pin_in(lo_pin_in), .hi_pin_in(hi_pin_in),
        .lo_pin_out(lo_pin_out), .hi_pin_out(hi_pin_out),
        .lo_evt(lo_evt), .hi_evt(hi_evt), .wd_expired(wd_expired)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Monitor: pops expected event cycles and compares them with observed events.
    always @(negedge clk) begin
        if (rst_n) begin
            if (lo_evt) begin
                lo_seen++;
                if (lo_q.size() == 0) check(cur_req, "unexpected lo_evt at cycle", cyc, -1);
                else check(cur_req, "lo_evt cycle", cyc, lo_q.pop_front());
            end
            while (lo_q.size() > 0 && lo_q[0] < cyc)
                check(cur_req, "missed lo_evt, now at cycle", cyc, lo_q.pop_front());
            if (hi_evt) begin
                hi_seen++;
                if (hi_q.size() == 0) check(cur_req, "unexpected hi_evt at cycle", cyc, -1);
                else check(cur_req, "hi_evt cycle", cyc, hi_q.pop_front());
            end
            while (hi_q.size() > 0 && hi_q[0] < cyc)
                check(cur_req, "missed hi_evt, now at cycle", cyc, hi_q.pop_front());
        end
    end

    // Driver: one register write; returns the cycle count seen right after its edge.
    task automatic wr(input logic [1:0] a, input int d, output int t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        t = cyc;
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic push_lo(input int t); lo_q.push_back(t); endtask
    task automatic push_hi(input int t); hi_q.push_back(t); endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lo_q.delete(); hi_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int e, s, base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "lo_evt", lo_evt, 0);
        check("R1", "hi_evt", hi_evt, 0);
        check("R1", "lo_pin_out", lo_pin_out, 0);
        check("R1", "hi_pin_out", hi_pin_out, 0);
        check("R1", "wd_expired", wd_expired, 0);

        // R2 / R6: chained, internal source, period 3
        cur_req = "R2";
        wr(2'd1, 3, e); wr(2'd2, 0, e);
        wr(2'd0, 1, e);
        push_lo(e + 24); push_lo(e + 48); push_lo(e + 72);
        wait_cyc(e + 80);
        check("R6", "lo_pin_out after 3 events", lo_pin_out, 1);
        check("R3", "hi events in chained mode", hi_seen, 0);

        // R3: chained carry, period {1,2} = 258
        cur_req = "R3";
        base = lo_seen;
        wr(2'd1, 2, e); wr(2'd2, 1, e);
        wr(2'd0, 1, e);
        check("R6", "lo_pin_out cleared by control write", lo_pin_out, 0);
        push_lo(e + 6 * 259); push_lo(e + 2 * 6 * 259);
        wait_cyc(e + 2 * 6 * 259 + 4);
        check("R3", "chained lo events", lo_seen - base, 2);
        check("R3", "hi_evt count stays zero", hi_seen, 0);

        // R4 / R5: split, low internal period 2, high external period 1
        cur_req = "R4";
        wr(2'd1, 2, e); wr(2'd2, 1, e);
        wr(2'd0, 2 | (1 << 3), e);
        push_lo(e + 18); push_lo(e + 36); push_lo(e + 54);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            hi_pin_in = 1'b1;
            if (i % 2 == 0) push_hi(cyc + 3);   // R5: every second edge, 3 clocks later
            repeat (4) @(negedge clk);
            hi_pin_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        wait_cyc(e + 60);
        check("R5", "hi events from 4 long pulses", hi_seen, 2);
        check("R6", "hi_pin_out after 2 toggles", hi_pin_out, 0);
        check("R6", "lo_pin_out after 3 toggles", lo_pin_out, 1);

        // R10: control write mid-period restarts counting
        cur_req = "R10";
        base = hi_seen;
        wr(2'd0, 2, e);
        wait_cyc(e + 10);
        wr(2'd0, 2, s);
        push_hi(s + 12); push_lo(s + 18); push_hi(s + 24);
        wait_cyc(s + 26);
        check("R10", "hi events after restart", hi_seen - base, 2);
        check("R10", "lo_pin_out one toggle since clear", lo_pin_out, 1);

        // R11: off mode silent
        cur_req = "R11";
        base = lo_seen + hi_seen;
        wr(2'd0, 0, e);
        wait_cyc(e + 100);
        check("R11", "events while off", lo_seen + hi_seen - base, 0);

        // R7: watchdog expiry after 3 ticks
        cur_req = "R7";
        wr(2'd1, 3, e); wr(2'd2, 0, e);
        wr(2'd0, 3, e);
        wait_cyc(e + 17);
        check("R7", "wd_expired one clock before expiry", wd_expired, 0);
        wait_cyc(e + 18);
        check("R7", "wd_expired at expiry", wd_expired, 1);

        // R9: sticky
        cur_req = "R9";
        wr(2'd3, 0, s);
        check("R9", "wd_expired after service", wd_expired, 1);
        wr(2'd0, 3, s);
        wait_cyc(s + 30);
        check("R9", "wd_expired after mode rewrite", wd_expired, 1);
        do_reset();
        @(negedge clk);
        check("R1", "wd_expired cleared by reset", wd_expired, 0);

        // R8: service reload restarts the countdown
        cur_req = "R8";
        wr(2'd1, 3, e);
        wr(2'd0, 3, e);
        wait_cyc(e + 14);
        wr(2'd3, 0, s);
        wait_cyc(s + 17);
        check("R8", "wd_expired before reloaded expiry", wd_expired, 0);
        wait_cyc(s + 18);
        check("R8", "wd_expired at reloaded expiry", wd_expired, 1);

        repeat (4) @(negedge clk);
        check("R4", "expected events left unseen", lo_q.size() + hi_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule